// File: doc/BRIEF.md
# Descriptor Writeback Bus Sequencer

This block is the bus-master engine that hands a ring descriptor back to software once the hardware has finished with its buffer. A single start pulse delivers a request. The request carries the descriptor base address, a 32-bit status value, a 16-bit ownership/extra-status word, a flag that marks an intermediate buffer of a chain, a layout mode and a burst-write enable. The sequencer then runs one or two write data phases on a multiplexed address/data bus, with active-high byte enables.

Intermediate chained buffers only need ownership returned, so they get one narrow write. A single-buffer descriptor, or the last buffer of a chain, gets the full status DWord first and then the ownership byte or word. In the burst-ordered 32-bit layout with burst writes enabled, both data phases share one address phase. Every data phase opens with one master wait cycle, during which initiator-ready stays low.

Top module: `dwb_writeback_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `cyc`, `adr_phase`, `irdy` and `done` are low, and `be` and `ad` are zero.
- R2: `start` is taken only while `busy` is low. A `start` pulse, or changed request inputs, during a running writeback has no effect on that writeback and starts no second one.
- R3: `layout` encoding: 00 and 01 select the 16-bit layout, 10 selects the 32-bit layout, 11 selects the burst-ordered 32-bit layout. `desc_base[1:0]` is ignored (B = base with low bits cleared). Status address: B+4 (16-bit), B+8 (32-bit), B+0 (burst-ordered). Ownership address: B+0 (16-bit), B+4 (both 32-bit layouts).
- R4: With `chain_mid`=1 exactly one data phase is made, and it carries only the ownership transfer.
- R5: With `chain_mid`=0 two data phases are made: first the status DWord with `be`=1111 and `ad`=`stat_word`, then the ownership transfer.
- R6: The ownership transfer enables only the lanes holding bit 31 of its word. In the 16-bit layout `be`=1000 and `ad`={own_word[15:8], 24'h0}. In the 32-bit layouts `be`=1100 and `ad`={own_word, 16'h0}.
- R7: Layout 11 with `burst_wr_en`=1 and `chain_mid`=0 makes one address phase followed by two data phases.
- R8: All other cases use a separate address phase per data phase, whatever `burst_wr_en` is. Between the two transactions `cyc` is low for exactly one cycle while `busy` stays high.
- R9: Every data phase starts with exactly one cycle in which `cyc` is high, `adr_phase` is low and `irdy` is low. After that cycle `irdy` is high until `tgt_rdy` completes the phase.
- R10: While `irdy` is high and `tgt_rdy` is low, `ad` and `be` hold their values.
- R11: `done` is a one-cycle pulse in the cycle after the final data phase completes. With `tgt_rdy` always high, it arrives 4, 6 or 8 cycles after the start edge, for single, burst and two-transaction writebacks respectively. Each cycle of target stall adds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken when idle |
| desc_base | input | 32 | Descriptor base address |
| stat_word | input | 32 | Status DWord to write |
| own_word | input | 16 | Extra status with ownership in bit 15 |
| chain_mid | input | 1 | Buffer is an intermediate link of a chain |
| layout | input | 2 | Descriptor layout mode |
| burst_wr_en | input | 1 | Permit burst writes in the burst-ordered layout |
| tgt_rdy | input | 1 | Target ready; completes a data phase with `irdy` |
| busy | output | 1 | Writeback in progress |
| cyc | output | 1 | Bus transaction active |
| adr_phase | output | 1 | Address phase cycle |
| irdy | output | 1 | Initiator ready |
| ad | output | 32 | Multiplexed address/data |
| be | output | 4 | Active-high byte enables |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the cases where the mode decode can go wrong. Burst enable is set in a layout that must not burst; a design that ignored the layout there would drop the second address phase and the idle gap. In the burst-ordered layout it checks that only a chained-intermediate writeback falls back to one narrow phase. A wrong address map or lane choice shows up as a wrong address, or as ownership data on the low lanes with `be`=0011. Target stalls check that the single wait cycle is not repeated and that data holds. A start pulse during a run catches a design that re-latches its request mid-flight or chains an extra writeback.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int OWN_W  = 16;
    localparam int LANES = DATA_W / 8;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_WAIT, S_DATA, S_GAP, S_DONE
    } dwb_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  be;
    } xfer_t;
endpackage

// File: rtl/dwb_plan.sv
module dwb_plan
    import dwb_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] stat,
    input  logic [OWN_W-1:0]  own,
    input  logic              mid,
    input  logic [1:0]        mode,
    input  logic              bwen,
    output xfer_t             x_first,
    output xfer_t             x_second,
    output logic              two,
    output logic              burst
);
    localparam int LANE_OWN16 = LANES - 1;
    localparam int LANE_OWN32 = LANES - OWN_W / 8;

    logic [ADDR_W-1:0] base_al;
    logic              wide;
    xfer_t             own_x;
    xfer_t             stat_x;

    always_comb begin
        base_al = {base[ADDR_W-1:2], 2'b00};
        wide    = mode[1];

        own_x = '0;
        if (wide) begin
            own_x.addr = base_al + ADDR_W'(4);
            own_x.data = {own, {(DATA_W-OWN_W){1'b0}}};
            for (int i = LANE_OWN32; i < LANES; i++) own_x.be[i] = 1'b1;
        end else begin
            own_x.addr = base_al;
            own_x.data = {own[OWN_W-1 -: 8], {(DATA_W-8){1'b0}}};
            own_x.be[LANE_OWN16] = 1'b1;
        end

        stat_x.data = stat;
        stat_x.be   = '1;
        case (mode)
            2'b11:   stat_x.addr = base_al;
            2'b10:   stat_x.addr = base_al + ADDR_W'(8);
            default: stat_x.addr = base_al + ADDR_W'(4);
        endcase

        two      = !mid;
        x_first  = mid ? own_x : stat_x;
        x_second = own_x;
        burst    = two && (mode == 2'b11) && bwen;
    end
endmodule

// File: rtl/dwb_seq.sv
module dwb_seq
    import dwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tgt_rdy,
    input  xfer_t             p_first,
    input  xfer_t             p_second,
    input  logic              p_two,
    input  logic              p_burst,
    output logic              busy,
    output logic              cyc,
    output logic              adr_phase,
    output logic              irdy,
    output logic [DATA_W-1:0] ad,
    output logic [LANES-1:0]  be,
    output logic              done
);
    typedef struct packed {
        dwb_state_e st;
        logic       idx;
        xfer_t      x0;
        xfer_t      x1;
        logic       two;
        logic       burst;
    } seq_t;

    seq_t  s_d, s_q;
    xfer_t cur;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            S_IDLE: if (start) begin
                s_d.st    = S_ADDR;
                s_d.idx   = 1'b0;
                s_d.x0    = p_first;
                s_d.x1    = p_second;
                s_d.two   = p_two;
                s_d.burst = p_burst;
            end
            S_ADDR: s_d.st = S_WAIT;
            S_WAIT: s_d.st = S_DATA;
            S_DATA: if (tgt_rdy) begin
                if (!s_q.idx && s_q.two) begin
                    s_d.idx = 1'b1;
                    s_d.st  = s_q.burst ? S_WAIT : S_GAP;
                end else begin
                    s_d.st = S_DONE;
                end
            end
            S_GAP:   s_d.st = S_ADDR;
            S_DONE:  s_d.st = S_IDLE;
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        cur       = s_q.idx ? s_q.x1 : s_q.x0;
        busy      = (s_q.st != S_IDLE);
        adr_phase = (s_q.st == S_ADDR);
        irdy      = (s_q.st == S_DATA);
        cyc       = adr_phase || irdy || (s_q.st == S_WAIT);
        done      = (s_q.st == S_DONE);
        ad        = '0;
        be        = '0;
        if (adr_phase) begin
            ad = DATA_W'(cur.addr);
        end else if (cyc) begin
            ad = cur.data;
            be = cur.be;
        end
    end
endmodule

// File: rtl/dwb_writeback_seq.sv
module dwb_writeback_seq
    import dwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [DATA_W-1:0] stat_word,
    input  logic [OWN_W-1:0]  own_word,
    input  logic              chain_mid,
    input  logic [1:0]        layout,
    input  logic              burst_wr_en,
    input  logic              tgt_rdy,
    output logic              busy,
    output logic              cyc,
    output logic              adr_phase,
    output logic              irdy,
    output logic [DATA_W-1:0] ad,
    output logic [LANES-1:0]  be,
    output logic              done
);
    xfer_t pl_first, pl_second;
    logic  pl_two, pl_burst;

    dwb_plan i_plan (
        .base     (desc_base),
        .stat     (stat_word),
        .own      (own_word),
        .mid      (chain_mid),
        .mode     (layout),
        .bwen     (burst_wr_en),
        .x_first  (pl_first),
        .x_second (pl_second),
        .two      (pl_two),
        .burst    (pl_burst)
    );

    dwb_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tgt_rdy   (tgt_rdy),
        .p_first   (pl_first),
        .p_second  (pl_second),
        .p_two     (pl_two),
        .p_burst   (pl_burst),
        .busy      (busy),
        .cyc       (cyc),
        .adr_phase (adr_phase),
        .irdy      (irdy),
        .ad        (ad),
        .be        (be),
        .done      (done)
    );
endmodule

// File: rtl/dwb_wb_checker.sv
module dwb_wb_checker
    import dwb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tgt_rdy,
    input logic              busy,
    input logic              cyc,
    input logic              adr_phase,
    input logic              irdy,
    input logic [DATA_W-1:0] ad,
    input logic [LANES-1:0]  be,
    input logic              done
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cyc && !irdy && !done && be == '0));

    p_addr_then_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        adr_phase |=> (cyc && !adr_phase && !irdy));

    p_wait_then_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && !adr_phase && !irdy) |=> irdy);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy && !tgt_rdy) |=> (irdy && $stable(ad) && $stable(be)));

    p_own_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy && be != '1) |-> ($countones(be) == 1 || $countones(be) == 2) && be[LANES-1]);

    p_status_not_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy && tgt_rdy && be == '1) |=> !done);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(irdy && tgt_rdy));
endmodule

bind dwb_writeback_seq dwb_wb_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_rdy   (tgt_rdy),
    .busy      (busy),
    .cyc       (cyc),
    .adr_phase (adr_phase),
    .irdy      (irdy),
    .ad        (ad),
    .be        (be),
    .done      (done)
);

// File: tb/test_dwb_writeback_seq.sv
module test_dwb_writeback_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] desc_base = '0;
    logic [31:0] stat_word = '0;
    logic [15:0] own_word = '0;
    logic        chain_mid = 1'b0;
    logic [1:0]  layout = 2'b00;
    logic        burst_wr_en = 1'b0;
    logic        tgt_rdy = 1'b0;
    logic        busy, cyc, adr_phase, irdy, done;
    logic [31:0] ad;
    logic [3:0]  be;

    always #5 clk = ~clk;

    dwb_writeback_seq i_dwb_writeback_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_base(desc_base),
        .stat_word(stat_word), .own_word(own_word), .chain_mid(chain_mid),
        .layout(layout), .burst_wr_en(burst_wr_en), .tgt_rdy(tgt_rdy),
        .busy(busy), .cyc(cyc), .adr_phase(adr_phase), .irdy(irdy),
        .ad(ad), .be(be), .done(done)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] l_addr [4];
    logic [31:0] l_data [4];
    logic [3:0]  l_be   [4];
    int n_addr, n_dat, n_wait, n_gap, stall_cfg, stall_left;

    always @(negedge clk) begin
        if (adr_phase) begin
            if (n_addr < 4) l_addr[n_addr] = ad;
            n_addr++;
        end
        if (cyc && !adr_phase && !irdy) n_wait++;
        if (busy && !cyc && !done) n_gap++;
        if (irdy && stall_left == 0) begin
            if (n_dat < 4) begin
                l_data[n_dat] = ad;
                l_be[n_dat]   = be;
            end
            n_dat++;
            tgt_rdy    = 1'b1;
            stall_left = stall_cfg;
        end else begin
            tgt_rdy = 1'b0;
            if (irdy) stall_left--;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_case(input logic [1:0] m, input logic bw, input logic mid,
                            input logic [31:0] b, input logic [31:0] s, input logic [15:0] o,
                            input int st, input bit poke);
        logic [31:0] bal, own_a, own_d, stat_a;
        logic [3:0]  own_b;
        bit two, bst;
        int e_dat, e_addr, e_gap, e_lat, lat;
        bal    = {b[31:2], 2'b00};
        own_a  = m[1] ? bal + 4 : bal;
        own_d  = m[1] ? {o, 16'h0} : {o[15:8], 24'h0};
        own_b  = m[1] ? 4'b1100 : 4'b1000;
        stat_a = (m == 2'b11) ? bal : (m == 2'b10) ? bal + 8 : bal + 4;
        two    = !mid;
        bst    = two && m == 2'b11 && bw;
        e_dat  = two ? 2 : 1;
        e_addr = bst ? 1 : e_dat;
        e_gap  = (two && !bst) ? 1 : 0;
        e_lat  = (two ? (bst ? 6 : 8) : 4) + st * e_dat;

        @(negedge clk);
        n_addr = 0; n_dat = 0; n_wait = 0; n_gap = 0;
        stall_cfg = st; stall_left = st;
        layout = m; burst_wr_en = bw; chain_mid = mid;
        desc_base = b; stat_word = s; own_word = o;
        start = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (poke && lat == 2) begin
                start = 1'b1;
                layout = ~m; chain_mid = ~mid; stat_word = ~s; desc_base = b + 32'h100;
            end
        end while (!done && lat < 60);

        chk(lat == e_lat, "R11 done latency", lat, e_lat);
        chk(n_dat == e_dat, "R4/R5 data phase count", n_dat, e_dat);
        chk(n_addr == e_addr, "R7/R8 address phase count", n_addr, e_addr);
        chk(n_wait == e_dat, "R9 one wait per data phase", n_wait, e_dat);
        chk(n_gap == e_gap, "R8 idle gap", n_gap, e_gap);
        if (two) begin
            chk(l_addr[0] == stat_a, "R3 status address", l_addr[0], stat_a);
            chk(l_data[0] == s && l_be[0] == 4'hF, "R5 status data/lanes", {l_be[0], l_data[0][27:0]}, {4'hF, s[27:0]});
            chk(l_data[1] == own_d, "R6 ownership data", l_data[1], own_d);
            chk(l_be[1] == own_b, "R6 ownership lanes", 32'(l_be[1]), 32'(own_b));
            if (!bst) chk(l_addr[1] == own_a, "R3 ownership address", l_addr[1], own_a);
        end else begin
            chk(l_addr[0] == own_a, "R4 ownership address", l_addr[0], own_a);
            chk(l_data[0] == own_d, "R4 ownership data", l_data[0], own_d);
            chk(l_be[0] == own_b, "R4 ownership lanes", 32'(l_be[0]), 32'(own_b));
        end
        @(negedge clk);
        chk(!busy && !done, "R11 done is one cycle", {30'h0, busy, done}, 32'h0);
        repeat (3) @(negedge clk);
        chk(n_addr == e_addr && !busy, "R2 no extra writeback", n_addr, e_addr);
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected finish");
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        join_none

        n_addr = 0; n_dat = 0; n_wait = 0; n_gap = 0; stall_cfg = 0; stall_left = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !cyc && !irdy && !done && !adr_phase && be == 0 && ad == 0,
            "R1 reset state", {busy, cyc, irdy, done, be, ad[23:0]}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !cyc && be == 0, "R1 idle after reset", {busy, cyc, 2'b0, be, 24'h0}, 32'h0);

        run_case(2'b10, 1'b0, 1'b0, 32'h0000_1000, 32'hA5A5_1234, 16'h8077, 0, 0); // R5 R6 R8
        run_case(2'b10, 1'b1, 1'b0, 32'h0000_2003, 32'h1111_2222, 16'h8123, 0, 0); // R8 burst ignored, R3 low bits
        run_case(2'b11, 1'b1, 1'b0, 32'h0000_3000, 32'hDEAD_BEEF, 16'h80F0, 0, 0); // R7
        run_case(2'b11, 1'b0, 1'b0, 32'h0000_4000, 32'h0BAD_F00D, 16'h8001, 0, 0); // R8 R3
        run_case(2'b00, 1'b1, 1'b0, 32'h0000_5000, 32'h7654_3210, 16'h81C3, 0, 0); // R6 16-bit
        run_case(2'b00, 1'b0, 1'b1, 32'h0000_6000, 32'hFFFF_FFFF, 16'h8055, 0, 0); // R4 byte
        run_case(2'b11, 1'b1, 1'b1, 32'h0000_7000, 32'h1234_5678, 16'h80AA, 0, 0); // R4 no burst
        run_case(2'b01, 1'b0, 1'b0, 32'h0000_8000, 32'hCAFE_0001, 16'h9F00, 0, 0); // R3 mode 01
        run_case(2'b11, 1'b1, 1'b0, 32'h0000_9000, 32'h5555_AAAA, 16'h8C3C, 2, 0); // R9 R10 stall
        run_case(2'b10, 1'b0, 1'b0, 32'h0000_A000, 32'h0F0F_0F0F, 16'h8421, 1, 0); // R10 stall
        run_case(2'b10, 1'b0, 1'b0, 32'h0000_B000, 32'h3C3C_3C3C, 16'h8765, 0, 1); // R2 poke

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule